// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Controller

This block models the control core of an asynchronous, byte-wide parallel NOR flash. A host talks to it only through active-low chip-enable, write-enable and output-enable strobes, an address bus and a shared 8-bit data bus. The strobes are sampled on an internal clock. Write cycles feed a command-sequence decoder. After two unlock writes, the decoder accepts either a byte-program request or a sector-erase request. Each request starts a self-timed job that runs against an on-chip byte array.

A program job takes a fixed number of cycles and can only clear bits. An erase job first walks the chosen sector writing zeros, then waits a settling interval, and then walks the sector again writing 0xFF. While a job runs, the ready output is low and reads return a status byte instead of array data. An erase can be suspended so that other sectors can be read and programmed, and later resumed from the point where it stopped. Sectors selected by a parameter mask are never altered. The asynchronous reset aborts any job in progress and returns the controller to array reads.

Top module: `nor_flash_ctrl`

## Requirements
- R1: While rst_ni is low, rdy_o is high and no job runs. Pulling rst_ni low during an erase aborts it at once. After release, new commands work normally.
- R2: The block drives data_io only while ce_ni and oe_ni are low and we_ni is high. When idle, such a read returns the array byte at addr_i.
- R3: The writes 0xAA at 0x555, 0x55 at 0x2AA and 0xA0 at 0x555, followed by one write of (address, data), start a program job. rdy_o is low for exactly PROG_CYC cycles, and afterwards the byte reads back. The address compare uses addr_i[10:0]. Program data 0xF0 is treated as data.
- R4: Programming stores old AND new, so a 0 bit never returns to 1.
- R5: While busy, a read returns a status byte. Bit 7 is the inverse of bit 7 of the byte being programmed, or 0 during an erase. Bit 6 flips on every read. Bits 5:0 are 0.
- R6: The writes 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30 at any address in a sector, start a sector erase. The erase first writes 0x00 to every byte of the sector in address order, then waits ERASE_CYC cycles, then writes 0xFF to every byte. rdy_o is low for 2*2^SAW+ERASE_CYC cycles. Other sectors are unchanged.
- R7: A write that does not match the next step of a sequence, or a 0xF0 write outside the program data step, returns the decoder to read mode, and no job starts.
- R8: Writing 0xB0 during a running erase suspends it. rdy_o goes high, the erase makes no further progress, and reads return array data. Programs to other sectors run normally. A program to the suspended sector is ignored.
- R9: While the erase is suspended and the decoder is idle, writing 0x30 resumes it. rdy_o goes low, and the erase completes with the whole sector at 0xFF.
- R10: A sector whose bit is set in PROT_MASK ignores program and erase requests. rdy_o stays high and the contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset; aborts jobs |
| ce_ni | input | 1 | Active-low chip enable |
| we_ni | input | 1 | Active-low write enable; a falling edge with ce_ni low is a write cycle |
| oe_ni | input | 1 | Active-low output enable |
| addr_i | input | AW | Byte address |
| data_io | inout | 8 | Shared data bus |
| rdy_o | output | 1 | High when no job is running |

## Verification
The hardest state to reach is an erase frozen partway through its zeroing pass, with a second job nested inside the suspension. The stimulus starts an erase of a sector that holds a known non-zero byte near its start and 0xFF near its end. It waits a fixed number of cycles before issuing the suspend, so that the zeroing pass is known to have passed the first byte but not the second. Reads then show 0x00 at the first byte and 0xFF at the second, even after further waiting. A program to another sector and an ignored program to the frozen sector run before the resume, and a final sweep confirms the whole sector is 0xFF.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [2:0] {SQ_IDLE, SQ_U1, SQ_U2, SQ_PRG, SQ_E1, SQ_E2, SQ_E3} seq_e;
  typedef enum logic [1:0] {EP_IDLE, EP_PRE, EP_WAIT, EP_FILL} ephase_e;

  localparam logic [7:0]  CMD_UNLK1 = 8'hAA;
  localparam logic [7:0]  CMD_UNLK2 = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERSU  = 8'h80;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_SUSP  = 8'hB0;
  localparam logic [7:0]  CMD_RST   = 8'hF0;
  localparam logic [10:0] ADR_U1    = 11'h555;
  localparam logic [10:0] ADR_U2    = 11'h2AA;
endpackage

// File: rtl/nfc_cmd_dec.sv
module nfc_cmd_dec
  import nfc_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          busy_i,
  input  logic          erase_run_i,
  input  logic          erase_susp_i,
  output logic          go_prog_o,
  output logic          go_erase_o,
  output logic          go_susp_o,
  output logic          go_resume_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [7:0]    cmd_data_o
);
  seq_e seq_q;
  logic hit1, hit2, at_u1;

  assign at_u1 = waddr_i[10:0] == ADR_U1;
  assign hit1  = at_u1 && wdata_i == CMD_UNLK1;
  assign hit2  = waddr_i[10:0] == ADR_U2 && wdata_i == CMD_UNLK2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q       <= SQ_IDLE;
      go_prog_o   <= 1'b0;
      go_erase_o  <= 1'b0;
      go_susp_o   <= 1'b0;
      go_resume_o <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      go_prog_o   <= 1'b0;
      go_erase_o  <= 1'b0;
      go_susp_o   <= 1'b0;
      go_resume_o <= 1'b0;
      if (wr_stb_i) begin
        cmd_addr_o <= waddr_i;
        cmd_data_o <= wdata_i;
        if (busy_i) begin
          // only suspend is honoured while a job runs
          seq_q <= SQ_IDLE;
          if (erase_run_i && wdata_i == CMD_SUSP) go_susp_o <= 1'b1;
        end else if (seq_q != SQ_PRG && wdata_i == CMD_RST) begin
          seq_q <= SQ_IDLE;
        end else begin
          unique case (seq_q)
            SQ_IDLE: begin
              if (hit1) seq_q <= SQ_U1;
              else if (erase_susp_i && wdata_i == CMD_SECT) go_resume_o <= 1'b1;
            end
            SQ_U1: seq_q <= hit2 ? SQ_U2 : SQ_IDLE;
            SQ_U2: begin
              if (at_u1 && wdata_i == CMD_PROG) seq_q <= SQ_PRG;
              else if (at_u1 && wdata_i == CMD_ERSU && !erase_susp_i) seq_q <= SQ_E1;
              else seq_q <= SQ_IDLE;
            end
            SQ_PRG: begin
              go_prog_o <= 1'b1;
              seq_q     <= SQ_IDLE;
            end
            SQ_E1: seq_q <= hit1 ? SQ_E2 : SQ_IDLE;
            SQ_E2: seq_q <= hit2 ? SQ_E3 : SQ_IDLE;
            SQ_E3: begin
              if (wdata_i == CMD_SECT) go_erase_o <= 1'b1;
              seq_q <= SQ_IDLE;
            end
            default: seq_q <= SQ_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/nfc_job.sv
module nfc_job
  import nfc_pkg::*;
#(
  parameter int AW        = 11,
  parameter int SAW       = 8,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 32,
  parameter logic [(1<<(AW-SAW))-1:0] PROT_MASK = 'h80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_prog_i,
  input  logic             go_erase_i,
  input  logic             go_susp_i,
  input  logic             go_resume_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [7:0]       cmd_data_i,
  output logic             p_act_o,
  output logic             p_dat7_o,
  output logic             e_act_o,
  output logic             e_susp_o,
  output logic [AW-SAW-1:0] e_sect_o,
  output logic             mem_we_o,
  output logic             mem_wand_o,
  output logic [AW-1:0]    mem_waddr_o,
  output logic [7:0]       mem_wdata_o
);
  localparam int SW  = AW - SAW;
  localparam int PCW = $clog2(PROG_CYC);
  localparam int ECW = $clog2(ERASE_CYC);

  logic [PCW-1:0] p_cnt;
  logic [AW-1:0]  p_addr;
  logic [7:0]     p_data;
  ephase_e        e_ph;
  logic [SAW-1:0] e_idx;
  logic [ECW-1:0] e_cnt;
  logic [SW-1:0]  cmd_sect;
  logic           prog_ok, erase_ok, p_done, e_go;

  assign cmd_sect = cmd_addr_i[AW-1:SAW];
  assign e_act_o  = e_ph != EP_IDLE;
  assign prog_ok  = go_prog_i && !PROT_MASK[cmd_sect] && !p_act_o &&
                    !(e_susp_o && cmd_sect == e_sect_o);
  assign erase_ok = go_erase_i && !PROT_MASK[cmd_sect] && !e_act_o;
  assign p_done   = p_act_o && p_cnt == PCW'(PROG_CYC - 1);
  assign e_go     = e_act_o && !e_susp_o && !p_act_o;
  assign p_dat7_o = p_data[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_act_o <= 1'b0;
      p_cnt   <= '0;
      p_addr  <= '0;
      p_data  <= '0;
    end else if (prog_ok) begin
      p_act_o <= 1'b1;
      p_cnt   <= '0;
      p_addr  <= cmd_addr_i;
      p_data  <= cmd_data_i;
    end else if (p_done) begin
      p_act_o <= 1'b0;
    end else if (p_act_o) begin
      p_cnt <= p_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_ph     <= EP_IDLE;
      e_susp_o <= 1'b0;
      e_sect_o <= '0;
      e_idx    <= '0;
      e_cnt    <= '0;
    end else if (erase_ok) begin
      e_ph     <= EP_PRE;
      e_susp_o <= 1'b0;
      e_sect_o <= cmd_sect;
      e_idx    <= '0;
    end else if (go_susp_i && e_act_o) begin
      e_susp_o <= 1'b1;
    end else if (go_resume_i && e_susp_o) begin
      e_susp_o <= 1'b0;
    end else if (e_go) begin
      unique case (e_ph)
        EP_PRE: begin
          e_idx <= e_idx + 1'b1;
          if (&e_idx) begin
            e_ph  <= EP_WAIT;
            e_cnt <= '0;
          end
        end
        EP_WAIT: begin
          if (e_cnt == ECW'(ERASE_CYC - 1)) e_ph <= EP_FILL;
          else e_cnt <= e_cnt + 1'b1;
        end
        EP_FILL: begin
          e_idx <= e_idx + 1'b1;
          if (&e_idx) e_ph <= EP_IDLE;
        end
        default: e_ph <= EP_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we_o    = p_done || (e_go && (e_ph == EP_PRE || e_ph == EP_FILL));
    mem_wand_o  = p_done;
    mem_waddr_o = p_done ? p_addr : {e_sect_o, e_idx};
    mem_wdata_o = p_done ? p_data : ((e_ph == EP_PRE) ? 8'h00 : 8'hFF);
  end
endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          and_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= and_i ? (mem[waddr_i] & wdata_i) : wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl #(
  parameter int AW        = 11,
  parameter int SAW       = 8,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 32,
  parameter logic [(1<<(AW-SAW))-1:0] PROT_MASK = 'h80
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  inout  wire  [7:0]    data_io,
  output logic          rdy_o
);
  localparam int SW = AW - SAW;

  logic we_q, oe_q, tog;
  logic wr_stb, rd_en, rd_start, busy;
  logic go_prog, go_erase, go_susp, go_resume;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic p_act, p_dat7, e_act, e_susp;
  logic [SW-1:0] e_sect;
  logic mem_we, mem_wand;
  logic [AW-1:0] mem_waddr;
  logic [7:0] mem_wdata, arr_rdata, stat, rd_data;

  assign wr_stb   = !ce_ni && !we_ni && we_q;
  assign rd_en    = !ce_ni && !oe_ni && we_ni;
  assign rd_start = rd_en && oe_q;
  assign busy     = p_act || (e_act && !e_susp);
  assign rdy_o    = !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
      tog  <= 1'b0;
    end else begin
      we_q <= we_ni;
      oe_q <= oe_ni || ce_ni;
      if (rd_start && busy) tog <= ~tog;
    end
  end

  assign stat    = {p_act ? ~p_dat7 : 1'b0, tog, 6'b0};
  assign rd_data = busy ? stat : arr_rdata;
  assign data_io = rd_en ? rd_data : 8'hzz;

  nfc_cmd_dec #(.AW(AW)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb_i(wr_stb),
    .waddr_i(addr_i), .wdata_i(data_io), .busy_i(busy),
    .erase_run_i(e_act && !e_susp), .erase_susp_i(e_susp),
    .go_prog_o(go_prog), .go_erase_o(go_erase), .go_susp_o(go_susp),
    .go_resume_o(go_resume), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
  );

  nfc_job #(
    .AW(AW), .SAW(SAW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .PROT_MASK(PROT_MASK)
  ) u_job (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_prog_i(go_prog), .go_erase_i(go_erase),
    .go_susp_i(go_susp), .go_resume_i(go_resume), .cmd_addr_i(cmd_addr),
    .cmd_data_i(cmd_data), .p_act_o(p_act), .p_dat7_o(p_dat7), .e_act_o(e_act),
    .e_susp_o(e_susp), .e_sect_o(e_sect), .mem_we_o(mem_we), .mem_wand_o(mem_wand),
    .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  nfc_array #(.AW(AW)) u_arr (
    .clk_i(clk_i), .we_i(mem_we), .and_i(mem_wand), .waddr_i(mem_waddr),
    .wdata_i(mem_wdata), .raddr_i(addr_i), .rdata_o(arr_rdata)
  );
endmodule

// File: rtl/nfc_checker.sv
module nfc_checker #(
  parameter int AW  = 11,
  parameter int SAW = 8,
  parameter logic [(1<<(AW-SAW))-1:0] PROT_MASK = 'h80
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rdy_o,
  input logic             mem_we,
  input logic             mem_wand,
  input logic [AW-1:0]    mem_waddr,
  input logic [AW-SAW-1:0] e_sect,
  input logic             e_susp,
  input logic             p_act,
  input logic             go_resume,
  input logic             rd_start,
  input logic             tog
);
  AST_PROT_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> !PROT_MASK[mem_waddr[AW-1:SAW]]);                         // R10
  AST_ERASE_IN_SECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && !mem_wand) |-> mem_waddr[AW-1:SAW] == e_sect);            // R6
  AST_SUSP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_susp && !p_act) |-> !mem_we);                                     // R8
  AST_RESUME_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_resume |=> !rdy_o);                                               // R9
  AST_TOG_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start && !rdy_o) |=> tog != $past(tog));                         // R5
endmodule

bind nor_flash_ctrl nfc_checker #(.AW(AW), .SAW(SAW), .PROT_MASK(PROT_MASK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rdy_o(rdy_o), .mem_we(mem_we), .mem_wand(mem_wand),
  .mem_waddr(mem_waddr), .e_sect(e_sect), .e_susp(e_susp), .p_act(p_act),
  .go_resume(go_resume), .rd_start(rd_start), .tog(tog)
);

// File: tb/tb_nor_flash_ctrl.sv
module tb_nor_flash_ctrl;
  localparam int AW = 11, SAW = 8, PROG_CYC = 16, ERASE_CYC = 32;
  localparam int ERASE_LEN = 2 * (1 << SAW) + ERASE_CYC;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, drv = 1'b0, smp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dout = '0;
  wire  [7:0] data_io;
  wire        rdy;

  assign data_io = drv ? dout : 8'hzz;
  always #10 clk = ~clk;

  nor_flash_ctrl #(.AW(AW), .SAW(SAW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                   .PROT_MASK(8'h80)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_io(data_io), .rdy_o(rdy)
  );

  int checks = 0, fails = 0;
  int low_run = 0, last_low = 0;
  bit low_seen = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] m_exp;
  string m_tag;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // busy-period monitor
  always @(negedge clk) begin
    if (!rdy) begin
      low_run++;
      low_seen = 1'b1;
    end else if (low_run != 0) begin
      last_low = low_run;
      low_run = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (smp && exp_q.size() > 0) begin
      m_exp = exp_q.pop_front();
      m_tag = tag_q.pop_front();
      chk(data_io == m_exp, m_tag, data_io, m_exp);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dout = d; drv = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk); drv = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); smp = 1'b1;
    @(negedge clk);
    @(posedge clk); smp = 1'b0;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_raw(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); v = data_io; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock();
    wr(11'h555, 8'hA0);
    wr(a, d);
  endtask

  task automatic erase(input logic [AW-1:0] a);
    unlock();
    wr(11'h555, 8'h80);
    unlock();
    wr(a, 8'h30);
  endtask

  task automatic wait_rdy();
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (rdy) break;
    end
    @(negedge clk);
  endtask

  task automatic clr_seen();
    @(posedge clk); low_seen = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] s1, s2, v;
    repeat (3) @(negedge clk);
    chk(rdy == 1'b1, "R1 ready in reset", rdy, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy == 1'b1, "R1 ready after reset", rdy, 1);

    // R2: bus released while chip is deselected
    @(negedge clk); drv = 1'b1; dout = 8'h96; oe_n = 1'b0;
    @(negedge clk); chk(data_io == 8'h96, "R2 bus released", data_io, 8'h96);
    oe_n = 1'b1; drv = 1'b0;

    erase(11'h000); wait_rdy();
    chk(last_low == ERASE_LEN, "R6 erase busy length", last_low, ERASE_LEN);
    erase(11'h100); wait_rdy();
    erase(11'h200); wait_rdy();
    rd_chk(11'h010, 8'hFF, "R6 erased byte");
    rd_chk(11'h1FF, 8'hFF, "R2 R6 erased byte");

    // R3/R5 program with status
    prog(11'h010, 8'h5A);
    rd_raw(11'h010, s1);
    rd_raw(11'h010, s2);
    chk(s1[7] == 1'b1, "R5 status bit7 inverted", s1[7], 1);
    chk(s1[6] != s2[6], "R5 bit6 toggles", s2[6], ~s1[6]);
    chk(s1[5:0] == 6'd0, "R5 low bits zero", s1[5:0], 0);
    wait_rdy();
    chk(last_low == PROG_CYC, "R3 program busy length", last_low, PROG_CYC);
    rd_chk(11'h010, 8'h5A, "R3 programmed byte");

    prog(11'h010, 8'hF0); wait_rdy();
    rd_chk(11'h010, 8'h50, "R4 and of old and new");

    prog(11'h011, 8'hA5);
    rd_raw(11'h011, s1);
    chk(s1[7] == 1'b0, "R5 status bit7 inverted", s1[7], 0);
    wait_rdy();

    // R7 broken sequences
    clr_seen();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h12); wr(11'h555, 8'hA0); wr(11'h012, 8'h00);
    unlock(); wr(11'h000, 8'hF0); wr(11'h555, 8'hA0); wr(11'h013, 8'h00);
    repeat (4) @(negedge clk);
    chk(low_seen == 1'b0, "R7 no job started", low_seen, 0);
    rd_chk(11'h012, 8'hFF, "R7 byte untouched");
    rd_chk(11'h013, 8'hFF, "R7 byte untouched");

    // R10 protected sector
    rd_raw(11'h710, v);
    clr_seen();
    prog(11'h710, 8'h00);
    erase(11'h700);
    repeat (4) @(negedge clk);
    chk(low_seen == 1'b0, "R10 no busy", low_seen, 0);
    rd_chk(11'h710, v, "R10 contents kept");

    // R6 other sectors unchanged
    prog(11'h110, 8'h33); wait_rdy();
    erase(11'h000); wait_rdy();
    rd_chk(11'h010, 8'hFF, "R6 sector erased");
    rd_chk(11'h110, 8'h33, "R6 other sector kept");

    // R8 suspend during the zeroing pass
    prog(11'h020, 8'h50); wait_rdy();
    erase(11'h000);
    repeat (60) @(negedge clk);
    wr(11'h000, 8'hB0);
    repeat (3) @(negedge clk);
    chk(rdy == 1'b1, "R8 ready while suspended", rdy, 1);
    rd_chk(11'h020, 8'h00, "R6 zeroing pass done first");
    rd_chk(11'h110, 8'h33, "R8 array read in suspend");
    prog(11'h130, 8'h3C); wait_rdy();
    rd_chk(11'h130, 8'h3C, "R8 program in suspend");
    clr_seen();
    prog(11'h040, 8'h00);
    repeat (20) @(negedge clk);
    chk(low_seen == 1'b0, "R8 program to suspended sector ignored", low_seen, 0);
    rd_chk(11'h0F0, 8'hFF, "R8 erase frozen");

    // R9 resume
    wr(11'h000, 8'h30);
    chk(rdy == 1'b0, "R9 busy after resume", rdy, 0);
    wait_rdy();
    rd_chk(11'h020, 8'hFF, "R9 erase completed");
    rd_chk(11'h0F0, 8'hFF, "R9 erase completed");
    rd_chk(11'h040, 8'hFF, "R9 erase completed");
    rd_chk(11'h130, 8'h3C, "R9 other sector kept");

    // R1 reset during erase
    erase(11'h200);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b1, "R1 reset aborts job", rdy, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rdy == 1'b1, "R1 stays ready", rdy, 1);
    rd_chk(11'h2F0, 8'hFF, "R1 erase stopped");
    prog(11'h2F0, 8'h81); wait_rdy();
    rd_chk(11'h2F0, 8'h81, "R1 commands after reset");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule